// File: doc/BRIEF.md
# Wavefront Fetch Eligibility Arbiter

This block picks, once per cycle, which hardware thread slot may start an instruction-line fetch. Every slot presents its execution state, a flag saying whether its fetch buffer still has a free line, and a stop-fetch flag. The block keeps an outstanding-fetch flag for each slot. A slot that qualifies is queued exactly once. Slots leave the queue in arrival order, at one grant per cycle.

A grant drives a one-cycle valid pulse together with the slot index, and it marks that slot as having a fetch in flight. The flag clears again when the fetch response for that slot comes back. A response can be flagged stale, meaning the slot dropped the line it had reserved, for instance after a branch flushed its buffer. A stale response still clears the flag, but the block tells the caller to discard its data. Address generation, translation, the memory path and decode are all outside this block.

Top module: `wf_fetch_arb`

## Requirements
- R1: A slot is queued only when all four of these hold: its 2-bit state field (`status_i[2*i+1:2*i]`) is 1 (running) or 2 (waiting on a counter), so 0 (idle) and 3 (halted) both block it; its `line_free_i` bit is 1; its `stop_i` bit is 0; and its outstanding flag is clear.
- R2: A slot that is already waiting in the queue is never added to it a second time. Each queued entry therefore produces exactly one grant, even when the slot stays eligible.
- R3: `grant_valid_o` is high for at most one slot per cycle, and only while the queue is not empty. With an empty queue it stays low.
- R4: When slot i is granted, `pending_o[i]` reads 1 from the next cycle onward. The slot is then not granted again until its flag clears.
- R5: A response (`resp_valid_i`=1, `resp_stale_i`=0) for slot s clears `pending_o[s]` on the next clock edge. In the same cycle, `resp_keep_o` is 1.
- R6: A stale response (`resp_stale_i`=1) also clears `pending_o[s]` on the next edge, but `resp_keep_o` stays 0, which tells the caller to discard the data.
- R7: Grants follow the order in which slots entered the queue. Slots that enter in the same cycle are ordered lowest index first, and a slot that enters later waits behind earlier entries whatever its index.
- R8: Reset (synchronous, active high) clears every outstanding flag and every in-queue flag, and empties the queue. In the cycle after reset, `pending_o` is 0 and `grant_valid_o` is 0.
- R9: A slot that becomes eligible in cycle t enters the queue at the end of t. If it is at the head of the queue, it is granted in cycle t+1. A cleared outstanding flag makes the slot eligible again no earlier than the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | 2*N | Per-slot state, 2 bits per slot (0 idle, 1 running, 2 waiting, 3 halted) |
| line_free_i | input | N | Slot's fetch buffer has a free line |
| stop_i | input | N | Slot asks for fetch to be held off |
| resp_valid_i | input | 1 | A fetch response returns this cycle |
| resp_slot_i | input | SW | Slot the response belongs to |
| resp_stale_i | input | 1 | Response line is no longer reserved by the slot |
| grant_valid_o | output | 1 | One slot is granted a fetch this cycle |
| grant_slot_o | output | SW | Index of the granted slot |
| pending_o | output | N | Per-slot outstanding-fetch flags |
| resp_keep_o | output | 1 | Response data is to be kept (valid and not stale) |

## Verification
The checker assumes that a response only ever names a slot whose outstanding flag is set, meaning one response per grant. Because a granted slot always has its flag clear at the moment of the grant, this assumption also rules out a response and a grant touching the same slot in one cycle. The stimulus keeps to it: every response in the bench targets a slot that was granted earlier and has not yet been answered, and only one response is driven per cycle.

// File: rtl/wf_fetch_pkg.sv
package wf_fetch_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_RUN  = 2'd1,
    WS_WAIT = 2'd2,
    WS_HALT = 2'd3
  } wave_state_e;

  // Width of a slot index; at least one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of an occupancy counter that can hold 0..n.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

  // States in which a slot is allowed to fetch.
  function automatic logic state_may_fetch(input logic [1:0] st);
    return (st == WS_RUN) || (st == WS_WAIT);
  endfunction

  // Full eligibility test for one slot.
  function automatic logic slot_eligible(input logic [1:0] st,
                                         input logic free_line,
                                         input logic stop,
                                         input logic pending);
    return state_may_fetch(st) && free_line && !stop && !pending;
  endfunction

endpackage

// File: rtl/wf_fetch_elig.sv
module wf_fetch_elig
  import wf_fetch_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [2*N-1:0] status_i,
  input  logic [N-1:0]   line_free_i,
  input  logic [N-1:0]   stop_i,
  input  logic [N-1:0]   pending_i,
  input  logic [N-1:0]   inq_i,
  output logic [N-1:0]   elig_o,
  output logic [N-1:0]   enq_o
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign elig_o[i] = slot_eligible(status_i[2*i +: 2], line_free_i[i],
                                     stop_i[i], pending_i[i]);
    assign enq_o[i]  = elig_o[i] && !inq_i[i];
  end

endmodule

// File: rtl/wf_fetch_flags.sv
module wf_fetch_flags #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant_v_i,
  input  logic [SW-1:0] grant_idx_i,
  input  logic          resp_v_i,
  input  logic [SW-1:0] resp_idx_i,
  input  logic [N-1:0]  enq_i,
  output logic [N-1:0]  pending_o,
  output logic [N-1:0]  inq_o
);

  logic [N-1:0] grant_oh;
  logic [N-1:0] resp_oh;
  logic [N-1:0] pending_r;
  logic [N-1:0] inq_r;

  assign grant_oh = grant_v_i ? (N'(1) << grant_idx_i) : '0;
  assign resp_oh  = resp_v_i  ? (N'(1) << resp_idx_i)  : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_r <= '0;
      inq_r     <= '0;
    end else begin
      pending_r <= (pending_r & ~resp_oh) | grant_oh;
      inq_r     <= (inq_r & ~grant_oh) | enq_i;
    end
  end

  assign pending_o = pending_r;
  assign inq_o     = inq_r;

endmodule

// File: rtl/wf_fetch_queue.sv
module wf_fetch_queue #(
  parameter int N  = 8,
  parameter int SW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  push_i,
  output logic          nonempty_o,
  output logic [SW-1:0] head_o,
  output logic [CW-1:0] count_o
);

  logic [SW-1:0] q_r [N];
  logic [SW-1:0] q_n [N];
  logic [CW-1:0] count_r;
  logic [CW-1:0] count_n;
  logic          pop;

  assign pop        = (count_r != '0);
  assign nonempty_o = pop;
  assign head_o     = q_r[0];
  assign count_o    = count_r;

  // Pop the head, then append this cycle's entrants lowest index first.
  always_comb begin
    logic [31:0] fill;
    for (int j = 0; j < N; j++) q_n[j] = q_r[j];
    fill = 32'(count_r);
    if (pop) begin
      for (int j = 0; j < N - 1; j++) q_n[j] = q_r[j+1];
      fill = fill - 32'd1;
    end
    for (int i = 0; i < N; i++) begin
      if (push_i[i] && (fill < 32'(N))) begin
        q_n[fill[SW-1:0]] = SW'(i);
        fill = fill + 32'd1;
      end
    end
    count_n = fill[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_r <= '0;
      for (int j = 0; j < N; j++) q_r[j] <= '0;
    end else begin
      count_r <= count_n;
      for (int j = 0; j < N; j++) q_r[j] <= q_n[j];
    end
  end

endmodule

// File: rtl/wf_fetch_arb.sv
module wf_fetch_arb
  import wf_fetch_pkg::*;
#(
  parameter int N  = 8,
  parameter int SW = idx_width(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2*N-1:0] status_i,
  input  logic [N-1:0]  line_free_i,
  input  logic [N-1:0]  stop_i,
  input  logic          resp_valid_i,
  input  logic [SW-1:0] resp_slot_i,
  input  logic          resp_stale_i,
  output logic          grant_valid_o,
  output logic [SW-1:0] grant_slot_o,
  output logic [N-1:0]  pending_o,
  output logic          resp_keep_o
);

  localparam int CW = cnt_width(N);

  logic [N-1:0]  elig_w;
  logic [N-1:0]  enq_w;
  logic [N-1:0]  inq_w;
  logic [N-1:0]  pend_w;
  logic          grant_w;
  logic [SW-1:0] head_w;
  logic [CW-1:0] count_w;

  wf_fetch_elig #(.N(N)) u_elig (
    .status_i    (status_i),
    .line_free_i (line_free_i),
    .stop_i      (stop_i),
    .pending_i   (pend_w),
    .inq_i       (inq_w),
    .elig_o      (elig_w),
    .enq_o       (enq_w)
  );

  wf_fetch_queue #(.N(N), .SW(SW), .CW(CW)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push_i     (enq_w),
    .nonempty_o (grant_w),
    .head_o     (head_w),
    .count_o    (count_w)
  );

  wf_fetch_flags #(.N(N), .SW(SW)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .grant_v_i   (grant_w),
    .grant_idx_i (head_w),
    .resp_v_i    (resp_valid_i),
    .resp_idx_i  (resp_slot_i),
    .enq_i       (enq_w),
    .pending_o   (pend_w),
    .inq_o       (inq_w)
  );

  assign grant_valid_o = grant_w;
  assign grant_slot_o  = head_w;
  assign pending_o     = pend_w;
  assign resp_keep_o   = resp_valid_i && !resp_stale_i;

endmodule

// File: rtl/wf_fetch_arb_chk.sv
module wf_fetch_arb_chk #(
  parameter int N  = 8,
  parameter int SW = 3,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  elig,
  input logic [N-1:0]  enq,
  input logic [N-1:0]  inq,
  input logic [CW-1:0] count,
  input logic          grant_valid,
  input logic [SW-1:0] grant_slot,
  input logic [N-1:0]  pending,
  input logic          resp_valid,
  input logic [SW-1:0] resp_slot,
  input logic          resp_stale,
  input logic          resp_keep
);

  p_enq_elig_r1: assert property (@(posedge clk) disable iff (rst)
    (enq & ~elig) == '0);

  p_enq_once_r2: assert property (@(posedge clk) disable iff (rst)
    (enq & inq) == '0);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    32'(count) <= 32'(N));

  p_grant_queued_r3: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> inq[grant_slot]);

  p_grant_free_r4: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> !pending[grant_slot]);

  p_grant_sets_r4: assert property (@(posedge clk) disable iff (rst)
    grant_valid |=> pending[$past(grant_slot)]);

  p_resp_clears_r5: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !pending[$past(resp_slot)]);

  p_stale_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_stale) |-> !resp_keep);

  // Input assumption: a response answers an outstanding fetch.
  p_resp_legal: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> pending[resp_slot]);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (pending == '0 && !grant_valid));

endmodule

bind wf_fetch_arb wf_fetch_arb_chk #(.N(N), .SW(SW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .elig        (elig_w),
  .enq         (enq_w),
  .inq         (inq_w),
  .count       (count_w),
  .grant_valid (grant_valid_o),
  .grant_slot  (grant_slot_o),
  .pending     (pending_o),
  .resp_valid  (resp_valid_i),
  .resp_slot   (resp_slot_i),
  .resp_stale  (resp_stale_i),
  .resp_keep   (resp_keep_o)
);

// File: tb/wf_fetch_arb_test.sv
module wf_fetch_arb_test;

  localparam int N  = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [2*N-1:0] status_i;
  logic [N-1:0]  line_free_i;
  logic [N-1:0]  stop_i;
  logic          resp_valid_i;
  logic [SW-1:0] resp_slot_i;
  logic          resp_stale_i;
  logic          grant_valid_o;
  logic [SW-1:0] grant_slot_o;
  logic [N-1:0]  pending_o;
  logic          resp_keep_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wf_fetch_arb #(.N(N)) uut (
    .clk           (clk),
    .rst           (rst),
    .status_i      (status_i),
    .line_free_i   (line_free_i),
    .stop_i        (stop_i),
    .resp_valid_i  (resp_valid_i),
    .resp_slot_i   (resp_slot_i),
    .resp_stale_i  (resp_stale_i),
    .grant_valid_o (grant_valid_o),
    .grant_slot_o  (grant_slot_o),
    .pending_o     (pending_o),
    .resp_keep_o   (resp_keep_o)
  );

  typedef struct packed {
    logic [15:0] st;
    logic [7:0]  fr;
    logic [7:0]  sp;
    logic        rv;
    logic [2:0]  rs;
    logic        rx;
    logic        gv;
    logic [2:0]  gs;
    logic [7:0]  pd;
    logic        kp;
    logic [3:0]  req;
  } vec_t;

  // One row per cycle: inputs, then outputs expected in that cycle.
  localparam vec_t VEC [17] = '{
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 4'd3},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 8'h00, 1'b0, 4'd7},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 8'h01, 1'b0, 4'd7},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd2, 8'h03, 1'b0, 4'd2},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd3, 8'h07, 1'b0, 4'd2},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd4, 8'h0F, 1'b0, 4'd4},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 8'h1F, 1'b0, 4'd4},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd6, 8'h3F, 1'b0, 4'd7},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd7, 8'h7F, 1'b0, 4'd7},
    '{16'h5555, 8'hFF, 8'h00, 1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 8'hFF, 1'b1, 4'd5},
    '{16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'hFB, 1'b0, 4'd9},
    '{16'h5555, 8'hFF, 8'h00, 1'b1, 3'd5, 1'b1, 1'b1, 3'd2, 8'hFB, 1'b0, 4'd6},
    '{16'h5555, 8'hFF, 8'h20, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'hDF, 1'b0, 4'd1},
    '{16'h5555, 8'hDF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'hDF, 1'b0, 4'd1},
    '{16'h5D55, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'hDF, 1'b0, 4'd1},
    '{16'h5955, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'hDF, 1'b0, 4'd1},
    '{16'h5955, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 8'hDF, 1'b0, 4'd4}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] st, input logic [7:0] fr,
                       input logic [7:0] sp, input logic rv,
                       input logic [2:0] rs, input logic rx);
    status_i     = st;
    line_free_i  = fr;
    stop_i       = sp;
    resp_valid_i = rv;
    resp_slot_i  = rs;
    resp_stale_i = rx;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(16'h0, 8'h0, 8'h0, 1'b0, 3'd0, 1'b0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8", "pending after reset", 32'(pending_o), 32'h0);
    check("R8", "grant after reset", 32'(grant_valid_o), 32'h0);

    // Vector table walk.
    for (int k = 0; k < 17; k++) begin
      @(negedge clk);
      drive(VEC[k].st, VEC[k].fr, VEC[k].sp, VEC[k].rv, VEC[k].rs, VEC[k].rx);
      #1;
      check(req_name(VEC[k].req), "grant_valid", 32'(grant_valid_o), 32'(VEC[k].gv));
      if (VEC[k].gv)
        check(req_name(VEC[k].req), "grant_slot", 32'(grant_slot_o), 32'(VEC[k].gs));
      check(req_name(VEC[k].req), "pending", 32'(pending_o), 32'(VEC[k].pd));
      check(req_name(VEC[k].req), "resp_keep", 32'(resp_keep_o), 32'(VEC[k].kp));
    end

    // Reset with all slots outstanding.
    @(negedge clk);
    rst = 1'b1;
    drive(16'h0, 8'h0, 8'h0, 1'b0, 3'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8", "pending cleared", 32'(pending_o), 32'h0);
    check("R8", "no grant", 32'(grant_valid_o), 32'h0);

    // FIFO order across cycles: 6,7 enter first, then 0.
    @(negedge clk);
    drive(16'h5000, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0);
    @(negedge clk);
    drive(16'h5001, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0);
    #1;
    check("R7", "first grant slot", 32'(grant_slot_o), 32'd6);
    check("R9", "grant one cycle after entry", 32'(grant_valid_o), 32'd1);
    @(negedge clk);
    #1;
    check("R7", "earlier entrant before lower index", 32'(grant_slot_o), 32'd7);
    @(negedge clk);
    #1;
    check("R7", "late entrant last", 32'(grant_slot_o), 32'd0);
    @(negedge clk);
    #1;
    check("R3", "empty queue no grant", 32'(grant_valid_o), 32'd0);
    check("R4", "granted slots outstanding", 32'(pending_o), 32'hC1);

    // Reset while entries are queued.
    @(negedge clk);
    drive(16'h5555, 8'hFF, 8'h00, 1'b0, 3'd0, 1'b0);
    @(negedge clk);
    #1;
    check("R7", "lowest queued slot", 32'(grant_slot_o), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8", "queue emptied", 32'(grant_valid_o), 32'd0);
    check("R8", "flags cleared", 32'(pending_o), 32'h0);
    @(negedge clk);
    #1;
    check("R9", "refill after reset grants slot 0", 32'(grant_slot_o), 32'd0);
    check("R9", "refill grant valid", 32'(grant_valid_o), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule